// File: doc/BRIEF.md
# Dual-Compare Periodic Up-Counter Timer

This block is one timer channel. A counter of parameterised width (16 bits by default) advances by one on every clock while its run bit is set. Two compare registers, A and B, are checked against the current count on every counting cycle, and each one has a sticky match flag. A sticky overflow flag records the wrap from the all-ones count back to zero. The interrupt request goes high when any flag is set and its enable is also set.

A two-bit clear-source field selects the counting mode. In free-running mode the counter wraps through its full range. In periodic mode it returns to zero on the clock after the count equals the selected compare register, so a compare value of N gives a period of N+1 counts. Software configures the channel through a simple single-cycle write port. Software can also preload the count and clear flags through that port.

Top module: `dual_cmp_timer`

## Requirements
- R1: While reset is applied and after it is released, `count` is 0, all flags are 0 and `irq` is 0. The run bit is 0 and the clear-source field is 00, which is free-running.
- R2: The counter does not change while the run bit (bit 0 of register 0) is 0. While the run bit is 1, the counter increments by one on each clock.
- R3: When the count is all ones, counting is enabled and no clear or load applies, the next clock takes the count to 0 and sets the overflow flag (`flags[0]`). Counting then continues up from 0.
- R4: On a counting cycle where the count equals compare A (register 1), match flag A (`flags[1]`) is set on the next clock. On a counting cycle where the count equals compare B (register 2), match flag B (`flags[2]`) is set on the next clock. This happens whatever the clear-source setting.
- R5: With the clear-source field (bits 2:1 of register 0) at 01, a count equal to compare A makes the next count 0. A compare value of N gives a period of N+1 counts.
- R6: With the clear-source field at 10, a count equal to compare B makes the next count 0. A match with compare A does not clear the count.
- R7: A clear-source field of 11 behaves as free-running. No compare match clears the count, but the match flags are still set.
- R8: Flags are sticky. A write to register 3 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. A flag set by hardware in the same cycle as a clear stays set.
- R9: `irq` is the OR of each flag ANDed with its enable in register 4. The enable bits use the same positions as the flags: bit 0 overflow, bit 1 A, bit 2 B. `irq` follows the flags and enables with no extra delay.
- R10: A write to register 5 loads the count on that clock. The load takes priority over counting and clearing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register select (0 control, 1 compare A, 2 compare B, 3 flag clear, 4 interrupt enables, 5 count load) |
| wr_data | input | CNT_W | Write data |
| count | output | CNT_W | Current count |
| flags | output | 3 | Sticky flags {match B, match A, overflow} |
| irq | output | 1 | Interrupt request |

## Verification
A write takes effect on the rising edge where it is sampled. The count, the flags and every configuration register change on that same edge. A compare match is seen on the count that is present before an edge, and both the match flag and the clear appear on the count after that edge. `irq` is decoded from the registered flags and enables, so it is valid in the same cycle as the flags. The bench drives each stimulus for exactly one rising edge and compares the outputs at the following falling edge. Every expected value is worked out by counting from the stimulus to that single edge.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int NFLAG   = 3;
  localparam int FLG_OVF = 0;
  localparam int FLG_MA  = 1;
  localparam int FLG_MB  = 2;
  localparam int NCMP    = 2;

  localparam int REG_CTRL = 0;
  localparam int REG_CMPA = 1;
  localparam int REG_CMPB = 2;
  localparam int REG_FLAG = 3;
  localparam int REG_IEN  = 4;
  localparam int REG_CNT  = 5;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_ON_A = 2'b01,
    CLR_ON_B = 2'b10,
    CLR_RSVD = 2'b11
  } clr_sel_e;
endpackage

// File: rtl/dct_rst_sync.sv
module dct_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dct_regs.sv
module dct_regs
  import dct_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int AW    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [CNT_W-1:0]            wr_data,
  output logic                        run,
  output clr_sel_e                    clr_sel,
  output logic [NCMP-1:0][CNT_W-1:0]  cmp,
  output logic [NFLAG-1:0]            ien,
  output logic                        load,
  output logic [CNT_W-1:0]            load_val,
  output logic                        flag_wr,
  output logic [NFLAG-1:0]            flag_wdata
);
  logic                       ctrl_we, ien_we;
  logic [NCMP-1:0]            cmp_we;
  logic                       run_q, run_d;
  clr_sel_e                   sel_q, sel_d;
  logic [NCMP-1:0][CNT_W-1:0] cmp_q, cmp_d;
  logic [NFLAG-1:0]           ien_q, ien_d;

  always_comb begin
    ctrl_we   = wr_en && (wr_addr == AW'(REG_CTRL));
    ien_we    = wr_en && (wr_addr == AW'(REG_IEN));
    cmp_we[0] = wr_en && (wr_addr == AW'(REG_CMPA));
    cmp_we[1] = wr_en && (wr_addr == AW'(REG_CMPB));
    run_d = wr_data[0];
    sel_d = clr_sel_e'(wr_data[2:1]);
    ien_d = wr_data[NFLAG-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sel_q <= CLR_NONE;
    end else if (ctrl_we) begin
      run_q <= run_d;
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_we) ien_q <= ien_d;
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    assign cmp_d[g] = wr_data;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cmp_q[g] <= '0;
      else if (cmp_we[g]) cmp_q[g] <= cmp_d[g];
    end
  end

  assign run        = run_q;
  assign clr_sel    = sel_q;
  assign cmp        = cmp_q;
  assign ien        = ien_q;
  assign load       = wr_en && (wr_addr == AW'(REG_CNT));
  assign load_val   = wr_data;
  assign flag_wr    = wr_en && (wr_addr == AW'(REG_FLAG));
  assign flag_wdata = wr_data[NFLAG-1:0];

  p_ctrl_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (run == $past(wr_data[0])));
endmodule

// File: rtl/dct_compare.sv
module dct_compare
  import dct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        active,
  input  clr_sel_e                    clr_sel,
  input  logic [CNT_W-1:0]            cnt,
  input  logic [NCMP-1:0][CNT_W-1:0]  cmp,
  output logic [NCMP-1:0]             match,
  output logic                        clr_hit
);
  logic [NCMP-1:0] eq;

  for (genvar g = 0; g < NCMP; g++) begin : g_eq
    assign eq[g]    = (cnt == cmp[g]);
    assign match[g] = active && eq[g];
  end

  always_comb begin
    unique case (clr_sel)
      CLR_ON_A: clr_hit = eq[0];
      CLR_ON_B: clr_hit = eq[1];
      default:  clr_hit = 1'b0;
    endcase
  end

  p_free_no_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sel == CLR_NONE || clr_sel == CLR_RSVD) |-> !clr_hit);
  p_b_mode_ignores_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sel == CLR_ON_B && cnt != cmp[1]) |-> !clr_hit);
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr_hit,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    wrap   = 1'b0;
    cnt_en = load || run;
    if (load) begin
      cnt_d = load_val;
    end else if (run) begin
      if (clr_hit) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
        wrap  = (cnt_q == CNT_MAX);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !clr_hit) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && clr_hit) |=> (cnt_q == '0));
  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/dct_flags.sv
module dct_flags
  import dct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] evt,
  input  logic             flag_wr,
  input  logic [NFLAG-1:0] flag_wdata,
  input  logic [NFLAG-1:0] ien,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  logic [NFLAG-1:0] flg_q, flg_d, flg_en, clr_req;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_comb begin
      clr_req[g] = flag_wr && !flag_wdata[g];
      flg_en[g]  = evt[g] || clr_req[g];
      flg_d[g]   = evt[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flg_q[g] <= 1'b0;
      else if (flg_en[g]) flg_q[g] <= flg_d[g];
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] |=> flg_q[g]);
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_q[g] && !clr_req[g]) |=> flg_q[g]);
    p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req[g] && !evt[g]) |=> !flg_q[g]);
  end

  assign flags = flg_q;
  assign irq   = |(flg_q & ien);
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  logic                       rst_i_n;
  logic                       run, load, flag_wr, clr_hit, wrap, active;
  clr_sel_e                   clr_sel;
  logic [NCMP-1:0][CNT_W-1:0] cmp;
  logic [NCMP-1:0]            match;
  logic [NFLAG-1:0]           ien, flag_wdata, evt;
  logic [CNT_W-1:0]           load_val, cnt;

  dct_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  dct_regs #(.CNT_W(CNT_W), .AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .run        (run),
    .clr_sel    (clr_sel),
    .cmp        (cmp),
    .ien        (ien),
    .load       (load),
    .load_val   (load_val),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata)
  );

  assign active = run && !load;

  dct_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .active  (active),
    .clr_sel (clr_sel),
    .cnt     (cnt),
    .cmp     (cmp),
    .match   (match),
    .clr_hit (clr_hit)
  );

  dct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .run      (run),
    .clr_hit  (clr_hit),
    .load     (load),
    .load_val (load_val),
    .cnt      (cnt),
    .wrap     (wrap)
  );

  always_comb begin
    evt          = '0;
    evt[FLG_OVF] = wrap;
    evt[FLG_MA]  = match[0];
    evt[FLG_MB]  = match[1];
  end

  dct_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .evt        (evt),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .ien        (ien),
    .flags      (flags),
    .irq        (irq)
  );

  assign count = cnt;

  p_wrap_ovf_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    wrap |=> (count == '0 && flags[FLG_OVF]));
endmodule

// File: tb/test_dual_cmp_timer.sv
module test_dual_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic [2:0]  flags;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_cmp_timer i_dual_cmp_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .flags(flags), .irq(irq)
  );

  // {wr, addr, data, exp_count, exp_flags{B,A,ovf}, exp_irq}
  localparam int NV = 24;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 3'd1, 16'd3, 16'd0, 3'b000, 1'b0}, // cmpA=3
    {1'b1, 3'd2, 16'd5, 16'd0, 3'b000, 1'b0}, // cmpB=5
    {1'b1, 3'd4, 16'd2, 16'd0, 3'b000, 1'b0}, // enable A
    {1'b1, 3'd0, 16'd3, 16'd0, 3'b000, 1'b0}, // run, clear on A
    {1'b0, 3'd0, 16'd0, 16'd1, 3'b000, 1'b0}, // R2
    {1'b0, 3'd0, 16'd0, 16'd2, 3'b000, 1'b0},
    {1'b0, 3'd0, 16'd0, 16'd3, 3'b000, 1'b0},
    {1'b0, 3'd0, 16'd0, 16'd0, 3'b010, 1'b1}, // R5 clear at A, R4, R9
    {1'b0, 3'd0, 16'd0, 16'd1, 3'b010, 1'b1},
    {1'b1, 3'd3, 16'd5, 16'd2, 3'b000, 1'b0}, // R8 clear A only
    {1'b0, 3'd0, 16'd0, 16'd3, 3'b000, 1'b0},
    {1'b0, 3'd0, 16'd0, 16'd0, 3'b010, 1'b1}, // R5 period 4
    {1'b1, 3'd0, 16'd5, 16'd1, 3'b010, 1'b1}, // clear on B
    {1'b1, 3'd3, 16'd0, 16'd2, 3'b000, 1'b0},
    {1'b0, 3'd0, 16'd0, 16'd3, 3'b000, 1'b0},
    {1'b0, 3'd0, 16'd0, 16'd4, 3'b010, 1'b1}, // R6 A match no clear
    {1'b0, 3'd0, 16'd0, 16'd5, 3'b010, 1'b1},
    {1'b0, 3'd0, 16'd0, 16'd0, 3'b110, 1'b1}, // R6 clear at B, R4
    {1'b1, 3'd4, 16'd0, 16'd1, 3'b110, 1'b0}, // R9 enables off
    {1'b1, 3'd3, 16'd0, 16'd2, 3'b000, 1'b0},
    {1'b1, 3'd1, 16'd4, 16'd3, 3'b000, 1'b0},
    {1'b0, 3'd0, 16'd0, 16'd4, 3'b000, 1'b0},
    {1'b1, 3'd3, 16'd0, 16'd5, 3'b010, 1'b0}, // R8 set wins over clear
    {1'b0, 3'd0, 16'd0, 16'd0, 3'b110, 1'b0}
  };

  function automatic string vreq(int i);
    case (i)
      4, 5, 6:    return "R2";
      7, 11:      return "R5";
      9, 22:      return "R8";
      15, 16, 17: return "R6";
      18:         return "R9";
      default:    return "R4";
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(logic w, logic [2:0] a, logic [15:0] d);
    wr_en = w; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_all(string req, logic [15:0] c, logic [2:0] f, logic i);
    chk(req, count, c);
    chk(req, {13'd0, flags}, {13'd0, f});
    chk(req, {15'd0, irq}, {15'd0, i});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R1", 16'd0, 3'b000, 1'b0);
    cyc(1'b0, 3'd0, 16'd0);
    chk_all("R1", 16'd0, 3'b000, 1'b0); // not running after reset

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][39], VEC[i][38:36], VEC[i][35:20]);
      chk_all(vreq(i), VEC[i][19:4], VEC[i][3:1], VEC[i][0]);
    end

    // R2: stop, then hold
    cyc(1'b1, 3'd0, 16'd4);
    chk("R2", count, 16'd1);
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, 3'd0, 16'd0);
      chk("R2", count, 16'd1);
    end

    // R10 load and R3 overflow
    cyc(1'b1, 3'd0, 16'd0);
    cyc(1'b1, 3'd3, 16'd0);
    chk("R8", {13'd0, flags}, 16'd0);
    cyc(1'b1, 3'd5, 16'hFFFE);
    chk("R10", count, 16'hFFFE);
    cyc(1'b1, 3'd0, 16'd1);
    chk("R2", count, 16'hFFFE);
    cyc(1'b0, 3'd0, 16'd0);
    chk("R3", count, 16'hFFFF);
    chk("R3", {13'd0, flags}, 16'd0);
    cyc(1'b0, 3'd0, 16'd0);
    chk_all("R3", 16'd0, 3'b001, 1'b0);
    cyc(1'b0, 3'd0, 16'd0);
    chk_all("R3", 16'd1, 3'b001, 1'b0);
    cyc(1'b1, 3'd4, 16'd1);
    chk_all("R9", 16'd2, 3'b001, 1'b1);
    cyc(1'b1, 3'd4, 16'd6);
    chk_all("R9", 16'd3, 3'b001, 1'b0);

    // R7: select 11 does not clear
    cyc(1'b1, 3'd0, 16'd6);
    chk("R7", count, 16'd4);
    cyc(1'b1, 3'd5, 16'd0);
    cyc(1'b1, 3'd3, 16'd0);
    cyc(1'b1, 3'd1, 16'd2);
    cyc(1'b1, 3'd0, 16'd7);
    chk_all("R7", 16'd0, 3'b000, 1'b0);
    cyc(1'b0, 3'd0, 16'd0);
    cyc(1'b0, 3'd0, 16'd0);
    chk("R7", count, 16'd2);
    cyc(1'b0, 3'd0, 16'd0);
    chk_all("R7", 16'd3, 3'b010, 1'b1);

    // R10 load while running
    cyc(1'b1, 3'd5, 16'd100);
    chk("R10", count, 16'd100);
    cyc(1'b0, 3'd0, 16'd0);
    chk("R10", count, 16'd101);

    // R8 writing ones leaves flags
    cyc(1'b1, 3'd3, 16'd7);
    chk_all("R8", 16'd102, 3'b010, 1'b1);

    // R1 reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk_all("R1", 16'd0, 3'b000, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R1", 16'd0, 3'b000, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule